// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Output Register

This block moves words from a write clock domain to an unrelated read clock domain. Each side has its own clock and synchronous active-low reset. The write and read pointers cross between the domains as Gray codes through a chain of synchronizer flops. On the read side, every word passes through an output register before it reaches the data pins. A word counts as being in memory only until it has been clocked into that register.

The read behaviour has two modes, chosen by a mode pin while the read-side reset is held:

- **Standard mode.** The output register takes a new word only when the reader asks for one. The flag means "memory holds at least one word".
- **Fall-through mode.** The head word moves into the output register without a request. The flag then means "the output register holds a fresh, unread word".

Both ports accept an operation only when all of the following hold:

- the chip select is low;
- the direction pin selects the port's own direction;
- the enable is high;
- the mailbox select is low;
- the port's own flag is high.

The block has no tristate pins. Instead it reports, through an output-enable signal, when the read data bus should be driven.

Top module: `xclk_fifo`

## Requirements
- R1: A word is stored on a rising `wr_clk` edge only when, at that edge, `wr_cs_n`=0, `wr_dir`=1, `wr_en`=1, `wr_mbox`=0 and `wr_ready`=1. Words leave the FIFO in the order they were stored.
- R2: `wr_ready` is low during reset and on the first edge after it. It is also low whenever the write side sees DEPTH words in memory, counted against the last synchronized read pointer. Write attempts while it is low store nothing.
- R3: In standard mode (mode pin 0 in reset), the output register loads the next word only on a rising `rd_clk` edge where `rd_cs_n`=0, `rd_dir`=1, `rd_en`=1, `rd_mbox`=0 and `rd_flag`=1. An attempt with `rd_flag`=0 leaves `rd_data` unchanged.
- R4: In standard mode, `rd_flag` is high exactly when memory holds an unread word as seen through the synchronizer. A word written into an empty memory raises it after the second rising `rd_clk` edge following the write edge.
- R5: In fall-through mode (mode pin 1 in reset), while `rd_flag` is low, a word written into memory is loaded without a request. This happens on the third rising `rd_clk` edge after its write edge, and that same edge raises `rd_flag`.
- R6: In fall-through mode, while `rd_flag` is high, the output register advances only on a qualified read. A qualified read with memory empty drops `rd_flag` and keeps the current word on `rd_data`.
- R7: No word is lost, duplicated or reordered, in either mode, under any mix of clock ratios and traffic.
- R8: `rd_data_oe` is high exactly when `rd_cs_n`=0 and `rd_dir`=1, independent of the other inputs.
- R9: The mode is latched only while `rd_rst_n` is low. Changing `fall_mode` afterwards has no effect on behaviour.
- R10: During reset, `rd_flag`=0, `wr_ready`=0 and the output register holds all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side synchronous reset, active low |
| wr_cs_n | input | 1 | Write-side chip select, active low |
| wr_dir | input | 1 | Write-side direction, 1 = write |
| wr_en | input | 1 | Write-side enable |
| wr_mbox | input | 1 | Mailbox select; must be 0 for FIFO access |
| wr_data | input | WIDTH | Word to store |
| wr_ready | output | 1 | Space available (full flag, inverted) |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side synchronous reset, active low |
| fall_mode | input | 1 | Read mode latched in reset: 0 standard, 1 fall-through |
| rd_cs_n | input | 1 | Read-side chip select, active low |
| rd_dir | input | 1 | Read-side direction, 1 = read |
| rd_en | input | 1 | Read-side enable |
| rd_mbox | input | 1 | Mailbox select; must be 0 for FIFO access |
| rd_data | output | WIDTH | Output register contents |
| rd_data_oe | output | 1 | Read data bus should be driven |
| rd_flag | output | 1 | Empty flag (standard) or output-ready (fall-through) |

## Verification
A pointer that steps on a non-qualified edge shows up at the ports as a wrong or repeated word. This is seen on the first read that reaches the bad location, and in fall-through mode within three read edges, because the word falls through unasked. A flag state machine stuck in the wrong state gives a `rd_flag` level that disagrees with the read-edge model at the very next read edge. A synchronizer of the wrong length shifts the flag rise by one edge. A miscomputed full compare lets a write overwrite an unread word, which shows up as corrupted order once that location is read.

// File: rtl/xcf_pkg.sv
// Shared types for the dual-clock FIFO.
// Assumes: nothing beyond the 2017 language standard.
package xcf_pkg;

    // Memory fill seen by the read side, as decoded from the pointer comparator
    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_ONE   = 2'd1,
        FILL_TWO   = 2'd2,
        FILL_MORE  = 2'd3
    } fill_e;

    // Read-side behaviour, latched during reset
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FALL = 1'b1
    } rd_mode_e;

endpackage

// File: rtl/xcf_sync.sv
// Multi-flop synchronizer for a Gray-coded pointer.
// Does: moves a vector into the destination clock domain through STAGES flops.
// Assumes: at most one bit of d changes between destination edges (Gray
// code), and STAGES >= 2.
module xcf_sync #(
    parameter int WIDTH  = 9,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the sampled vector along the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/xcf_mem.sv
// Storage array for the dual-clock FIFO.
// Does: registered write on the write clock, combinational read at an
// address owned by the read domain.
// Assumes: the read side never addresses a slot whose write is less than one
// synchronizer delay old (guaranteed by the pointer protocol).
module xcf_mem #(
    parameter int WIDTH = 36,
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             wclk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] cells [DEPTH];

    // Store one word per qualified write
    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/xcf_wr_side.sv
// Write-domain control of the dual-clock FIFO.
// Does: qualifies writes, advances the binary and Gray write pointers, and
// computes the full condition against the synchronized read pointer.
// Assumes: rd_gray_s already crossed into this domain; AW >= 2.
module xcf_wr_side #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          dir,
    input  logic          en,
    input  logic          mbox,
    input  logic [AW:0]   rd_gray_s,
    output logic          fire,
    output logic [AW-1:0] addr,
    output logic [AW:0]   ptr,
    output logic [AW:0]   gray,
    output logic          ready
);

    logic [AW:0] ptr_q;
    logic [AW:0] gray_q;
    logic [AW:0] ptr_nxt;
    logic        live_q;
    logic        full;

    // Full when the write pointer sits one lap ahead of the read pointer
    always_comb begin
        full = (gray_q == {~rd_gray_s[AW:AW-1], rd_gray_s[AW-2:0]});
    end

    assign ptr_nxt = ptr_q + 1'b1;
    assign ready   = live_q & ~full;
    assign fire    = ~cs_n & dir & en & ~mbox & ready;

    // Advance the pointers on each accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            gray_q <= '0;
            live_q <= 1'b0;
        end else begin
            live_q <= 1'b1;
            if (fire) begin
                ptr_q  <= ptr_nxt;
                gray_q <= ptr_nxt ^ (ptr_nxt >> 1);
            end
        end
    end

    assign addr = ptr_q[AW-1:0];
    assign ptr  = ptr_q;
    assign gray = gray_q;

endmodule

// File: rtl/xcf_rd_side.sv
// Read-domain control of the dual-clock FIFO.
// Does: decodes the memory fill from the synchronized write pointer, runs
// the output-register state machine for standard and fall-through modes,
// and advances the read pointer each time a word enters the output register.
// Assumes: wr_gray_s already crossed into this domain; the mode is only
// sampled while rst_n is low.
module xcf_rd_side
    import xcf_pkg::*;
#(
    parameter int WIDTH = 36,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_pin,
    input  logic             cs_n,
    input  logic             dir,
    input  logic             en,
    input  logic             mbox,
    input  logic [AW:0]      wr_gray_s,
    input  logic [WIDTH-1:0] mem_rdata,
    output logic [AW-1:0]    addr,
    output logic [AW:0]      ptr,
    output logic [AW:0]      gray,
    output logic [WIDTH-1:0] data,
    output logic             flag,
    output logic             oe,
    output rd_mode_e         mode
);

    logic [AW:0]      wr_bin_s;
    logic [AW:0]      fill_cnt;
    fill_e            level;
    logic             read_req;
    logic             take;
    logic             rdy_q;
    logic             rdy_nxt;
    logic [AW:0]      ptr_q;
    logic [AW:0]      gray_q;
    logic [AW:0]      ptr_nxt;
    logic [WIDTH-1:0] data_q;
    rd_mode_e         mode_q;

    // Gray to binary for the synchronized write pointer
    always_comb begin
        for (int i = 0; i <= AW; i++) begin
            wr_bin_s[i] = ^(wr_gray_s >> i);
        end
    end

    // Pointer comparator: empty, empty+1, empty+2 or more
    always_comb begin
        fill_cnt = wr_bin_s - ptr_q;
        if (fill_cnt == '0) begin
            level = FILL_EMPTY;
        end else if (fill_cnt == (AW+1)'(1)) begin
            level = FILL_ONE;
        end else if (fill_cnt == (AW+1)'(2)) begin
            level = FILL_TWO;
        end else begin
            level = FILL_MORE;
        end
    end

    assign read_req = ~cs_n & dir & en & ~mbox;

    // Decide whether a word enters the output register this edge
    always_comb begin
        take    = 1'b0;
        rdy_nxt = rdy_q;
        if (mode_q == MODE_STD) begin
            take = read_req && (level != FILL_EMPTY);
        end else if (!rdy_q) begin
            if (level != FILL_EMPTY) begin
                take    = 1'b1;
                rdy_nxt = 1'b1;
            end
        end else if (read_req) begin
            if (level != FILL_EMPTY) begin
                take = 1'b1;
            end else begin
                rdy_nxt = 1'b0;
            end
        end
    end

    // Latch the read mode while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= mode_pin ? MODE_FALL : MODE_STD;
        end
    end

    assign ptr_nxt = ptr_q + 1'b1;

    // Output register, ready state and read pointer update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            gray_q <= '0;
            data_q <= '0;
            rdy_q  <= 1'b0;
        end else begin
            rdy_q <= rdy_nxt;
            if (take) begin
                data_q <= mem_rdata;
                ptr_q  <= ptr_nxt;
                gray_q <= ptr_nxt ^ (ptr_nxt >> 1);
            end
        end
    end

    assign flag = (mode_q == MODE_FALL) ? rdy_q : (level != FILL_EMPTY);
    assign oe   = ~cs_n & dir;
    assign addr = ptr_q[AW-1:0];
    assign ptr  = ptr_q;
    assign gray = gray_q;
    assign data = data_q;
    assign mode = mode_q;

endmodule

// File: rtl/xclk_fifo.sv
// Dual-clock FIFO with a registered output stage and two read modes.
// Does: joins the write control, storage, pointer synchronizers and read
// control. The flag latency from a write is SYNC_DEPTH read edges in
// standard mode and SYNC_DEPTH+1 in fall-through mode.
// Assumes: DEPTH is a power of two and at least 4; SYNC_DEPTH >= 2; both
// resets are held together for a few cycles of the slower clock.
module xclk_fifo
    import xcf_pkg::*;
#(
    parameter int WIDTH      = 36,
    parameter int DEPTH      = 256,
    parameter int SYNC_DEPTH = 2
) (
    input  logic             wr_clk,
    input  logic             wr_rst_n,
    input  logic             wr_cs_n,
    input  logic             wr_dir,
    input  logic             wr_en,
    input  logic             wr_mbox,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_ready,
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    input  logic             fall_mode,
    input  logic             rd_cs_n,
    input  logic             rd_dir,
    input  logic             rd_en,
    input  logic             rd_mbox,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_data_oe,
    output logic             rd_flag
);

    localparam int AW = $clog2(DEPTH);

    logic             mem_we;
    logic [AW-1:0]    mem_waddr;
    logic [AW-1:0]    mem_raddr;
    logic [WIDTH-1:0] mem_rdata;
    logic [AW:0]      w_ptr;
    logic [AW:0]      w_gray;
    logic [AW:0]      r_ptr;
    logic [AW:0]      r_gray;
    logic [AW:0]      w_gray_rs;
    logic [AW:0]      r_gray_ws;
    rd_mode_e         mode_q;

    xcf_wr_side #(.AW(AW)) wr_side_i (
        .clk       (wr_clk),
        .rst_n     (wr_rst_n),
        .cs_n      (wr_cs_n),
        .dir       (wr_dir),
        .en        (wr_en),
        .mbox      (wr_mbox),
        .rd_gray_s (r_gray_ws),
        .fire      (mem_we),
        .addr      (mem_waddr),
        .ptr       (w_ptr),
        .gray      (w_gray),
        .ready     (wr_ready)
    );

    xcf_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) mem_i (
        .wclk  (wr_clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    xcf_sync #(.WIDTH(AW+1), .STAGES(SYNC_DEPTH)) w2r_sync_i (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (w_gray),
        .q     (w_gray_rs)
    );

    xcf_sync #(.WIDTH(AW+1), .STAGES(SYNC_DEPTH)) r2w_sync_i (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (r_gray),
        .q     (r_gray_ws)
    );

    xcf_rd_side #(.WIDTH(WIDTH), .AW(AW)) rd_side_i (
        .clk       (rd_clk),
        .rst_n     (rd_rst_n),
        .mode_pin  (fall_mode),
        .cs_n      (rd_cs_n),
        .dir       (rd_dir),
        .en        (rd_en),
        .mbox      (rd_mbox),
        .wr_gray_s (w_gray_rs),
        .mem_rdata (mem_rdata),
        .addr      (mem_raddr),
        .ptr       (r_ptr),
        .gray      (r_gray),
        .data      (rd_data),
        .flag      (rd_flag),
        .oe        (rd_data_oe),
        .mode      (mode_q)
    );

endmodule

// File: rtl/xclk_fifo_chk.sv
// Property checker for xclk_fifo, attached by bind.
// Does: relates the port qualifiers and flags to pointer and output-register
// movement in each clock domain.
// Assumes: resets are synchronous and active low.
module xclk_fifo_chk #(
    parameter int AW    = 8,
    parameter int WIDTH = 36
) (
    input logic             wr_clk,
    input logic             wr_rst_n,
    input logic             rd_clk,
    input logic             rd_rst_n,
    input logic             wr_cs_n,
    input logic             wr_dir,
    input logic             wr_en,
    input logic             wr_mbox,
    input logic             wr_ready,
    input logic             rd_flag,
    input logic [WIDTH-1:0] rd_data,
    input logic             fall_q,
    input logic [AW:0]      w_ptr,
    input logic [AW:0]      r_ptr
);

    // R1: an unqualified write edge leaves the write pointer alone
    a_r1_write_needs_qualifiers: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_cs_n || !wr_dir || !wr_en || wr_mbox) |=> $stable(w_ptr));

    // R2: no write is taken while ready is low
    a_r2_no_write_blocked: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (!wr_ready) |=> $stable(w_ptr));

    // R3: standard mode with the flag low moves neither pointer nor data
    a_r3_std_ignore_when_empty: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (!fall_q && !rd_flag) |=> ($stable(r_ptr) && $stable(rd_data)));

    // R5: in fall-through mode a load from the not-ready state raises the flag
    a_r5_fall_load_raises_flag: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (fall_q && !rd_flag) |=> (rd_flag || ($stable(r_ptr) && $stable(rd_data))));

    // R6: dropping the flag in fall-through mode keeps the current word
    a_r6_fall_drop_keeps_word: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (fall_q && $fell(rd_flag)) |-> ($stable(rd_data) && $stable(r_ptr)));

    // R9: the latched mode never changes outside reset
    a_r9_mode_frozen: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_rst_n |=> $stable(fall_q));

endmodule

bind xclk_fifo xclk_fifo_chk #(.AW(AW), .WIDTH(WIDTH)) chk_i (
    .wr_clk   (wr_clk),
    .wr_rst_n (wr_rst_n),
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .wr_cs_n  (wr_cs_n),
    .wr_dir   (wr_dir),
    .wr_en    (wr_en),
    .wr_mbox  (wr_mbox),
    .wr_ready (wr_ready),
    .rd_flag  (rd_flag),
    .rd_data  (rd_data),
    .fall_q   (mode_q),
    .w_ptr    (w_ptr),
    .r_ptr    (r_ptr)
);

// File: tb/xclk_fifo_tb_top.sv
`timescale 1ns/100ps
// Bench for xclk_fifo: a behavioural per-edge model in each clock domain,
// compared against the ports on the opposite clock edge.
module xclk_fifo_tb_top;

    localparam int W = 36;
    localparam int D = 16;

    logic         wr_clk = 1'b0;
    logic         rd_clk = 1'b0;
    logic         wr_rst_n = 1'b0;
    logic         rd_rst_n = 1'b0;
    logic         fall_mode = 1'b0;
    logic         wr_cs_n = 1'b1;
    logic         wr_dir = 1'b0;
    logic         wr_en = 1'b0;
    logic         wr_mbox = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         rd_cs_n = 1'b0;
    logic         rd_dir = 1'b1;
    logic         rd_en = 1'b0;
    logic         rd_mbox = 1'b0;
    logic         wr_ready;
    logic [W-1:0] rd_data;
    logic         rd_data_oe;
    logic         rd_flag;

    // 250 MHz write clock; read clock at an unrelated 7 ns period whose
    // rising edges never coincide with write-clock edges
    always #2 wr_clk = ~wr_clk;
    always #3.5 rd_clk = ~rd_clk;

    xclk_fifo #(.WIDTH(W), .DEPTH(D), .SYNC_DEPTH(2)) dut_i (
        .wr_clk     (wr_clk),
        .wr_rst_n   (wr_rst_n),
        .wr_cs_n    (wr_cs_n),
        .wr_dir     (wr_dir),
        .wr_en      (wr_en),
        .wr_mbox    (wr_mbox),
        .wr_data    (wr_data),
        .wr_ready   (wr_ready),
        .rd_clk     (rd_clk),
        .rd_rst_n   (rd_rst_n),
        .fall_mode  (fall_mode),
        .rd_cs_n    (rd_cs_n),
        .rd_dir     (rd_dir),
        .rd_en      (rd_en),
        .rd_mbox    (rd_mbox),
        .rd_data    (rd_data),
        .rd_data_oe (rd_data_oe),
        .rd_flag    (rd_flag)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit mon_on = 1'b0;

    // Reference model state
    int           wc = 0, rs1 = 0, rs2 = 0;
    int           rc = 0, ws1 = 0, ws2 = 0;
    int           avail;
    bit           req;
    bit           w_live = 1'b0;
    bit           m_or = 1'b0;
    bit           m_mode = 1'b0;
    logic [W-1:0] m_out = '0;
    logic [W-1:0] mq[$];

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Write-domain model: accept, then see the read count two edges late
    always @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            w_live = 1'b0; wc = 0; rs1 = 0; rs2 = 0;
            mq.delete();
        end else begin
            if (w_live && (wc - rs2) < D && !wr_cs_n && wr_dir && wr_en && !wr_mbox) begin
                mq.push_back(wr_data);
                wc++;
            end
            rs2 = rs1; rs1 = rc; w_live = 1'b1;
        end
    end

    // Read-domain model: standard and fall-through output register
    always @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            m_mode = fall_mode; rc = 0; ws1 = 0; ws2 = 0; m_or = 1'b0; m_out = '0;
        end else begin
            avail = ws2 - rc;
            req = !rd_cs_n && rd_dir && rd_en && !rd_mbox;
            if (!m_mode) begin
                if (req && avail > 0) begin m_out = mq[rc]; rc++; end
            end else if (!m_or) begin
                if (avail > 0) begin m_out = mq[rc]; rc++; m_or = 1'b1; end
            end else if (req) begin
                if (avail > 0) begin m_out = mq[rc]; rc++; end
                else m_or = 1'b0;
            end
            ws2 = ws1; ws1 = wc;
        end
    end

    // Per-edge comparison, write side (R2, R10)
    always @(negedge wr_clk) begin
        if (mon_on) check("R2 wr_ready", W'(wr_ready), W'(w_live && (wc - rs2) < D));
    end

    // Per-edge comparison, read side (R4 R5 R6 R7 R8 R9 R1 R3)
    always @(negedge rd_clk) begin
        if (mon_on) begin
            if (m_mode) check("R5/R6/R9 rd_flag fall-through", W'(rd_flag), W'(m_or));
            else        check("R4/R9 rd_flag standard", W'(rd_flag), W'((ws2 - rc) > 0));
            check("R8 rd_data_oe", W'(rd_data_oe), W'(!rd_cs_n && rd_dir));
            if (rd_data_oe) check("R7/R1/R3/R6 rd_data", rd_data, m_out);
        end
    end

    task automatic wr_idle();
        wr_cs_n = 1'b1; wr_dir = 1'b0; wr_en = 1'b0; wr_mbox = 1'b0;
    endtask

    task automatic rd_idle();
        rd_cs_n = 1'b0; rd_dir = 1'b1; rd_en = 1'b0; rd_mbox = 1'b0;
    endtask

    task automatic do_reset(input bit mode);
        @(negedge wr_clk);
        wr_rst_n = 1'b0; rd_rst_n = 1'b0; fall_mode = mode;
        wr_idle(); rd_idle();
        repeat (4) @(negedge rd_clk);
        @(negedge wr_clk);
        mon_on = 1'b1;
        check("R10 wr_ready in reset", W'(wr_ready), '0);
        check("R10 rd_flag in reset", W'(rd_flag), '0);
        check("R10 rd_data in reset", rd_data, '0);
        wr_rst_n = 1'b1; rd_rst_n = 1'b1;
        @(negedge wr_clk);
        fall_mode = ~mode;
    endtask

    task automatic wr_traffic(input int n, input int pct);
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            if ($urandom_range(99) < pct) begin
                wr_cs_n = 1'b0; wr_dir = 1'b1; wr_en = 1'b1; wr_mbox = 1'b0;
            end else begin
                wr_cs_n = 1'($urandom_range(1)); wr_dir = 1'($urandom_range(1));
                wr_en = 1'($urandom_range(1)); wr_mbox = 1'($urandom_range(1));
            end
            wr_data = W'({$urandom(), $urandom()});
        end
        @(negedge wr_clk);
        wr_idle();
    endtask

    task automatic rd_traffic(input int n, input int pct);
        for (int i = 0; i < n; i++) begin
            @(negedge rd_clk);
            if ($urandom_range(99) < pct) begin
                rd_cs_n = 1'b0; rd_dir = 1'b1; rd_en = 1'b1; rd_mbox = 1'b0;
            end else begin
                rd_cs_n = 1'($urandom_range(1)); rd_dir = 1'($urandom_range(1));
                rd_en = 1'($urandom_range(1)); rd_mbox = 1'($urandom_range(1));
            end
        end
        @(negedge rd_clk);
        rd_idle();
    endtask

    // Directed latency from one write into an empty FIFO (R4 / R5),
    // then one read that empties it (R3 / R6)
    task automatic latency(input bit mode);
        logic [W-1:0] word;
        int cnt;
        word = W'(36'h5A5A_0C3C1);
        @(negedge wr_clk);
        wr_cs_n = 1'b0; wr_dir = 1'b1; wr_en = 1'b1; wr_mbox = 1'b0; wr_data = word;
        @(posedge wr_clk);
        cnt = 0;
        fork
            begin #1 wr_idle(); end
            begin
                for (int k = 0; k < 8; k++) begin
                    @(posedge rd_clk);
                    cnt++;
                    @(negedge rd_clk);
                    if (rd_flag) break;
                end
            end
        join
        if (mode) check("R5 fall-through latency in read edges", W'(cnt), W'(3));
        else      check("R4 standard latency in read edges", W'(cnt), W'(2));
        if (mode) check("R5 word present without request", rd_data, word);
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_idle();
        if (mode) check("R6 flag drops on read of empty", W'(rd_flag), '0);
        else      check("R3 flag low after last word read", W'(rd_flag), '0);
        check("R3/R6 word kept on output", rd_data, word);
        // attempt with flag low must not change the output
        @(negedge rd_clk);
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_idle();
        check("R3/R6 ignored attempt keeps word", rd_data, word);
    endtask

    task automatic run_mode(input bit mode);
        do_reset(mode);
        latency(mode);
        wr_traffic(D + 6, 100);
        repeat (4) @(negedge wr_clk);
        check("R2 wr_ready low when full", W'(wr_ready), '0);
        rd_traffic(D * 3, 100);
        fork
            wr_traffic(1500, 60);
            rd_traffic(900, 70);
        join
        rd_traffic(D * 4, 100);
        fork
            wr_traffic(800, 30);
            rd_traffic(500, 95);
        join
        rd_traffic(D * 4, 100);
    endtask

    // Watchdog: an expired run counts as a failure and still reports
    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        run_mode(1'b0);
        run_mode(1'b1);
        repeat (4) @(negedge wr_clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule